// File: doc/BRIEF.md
# Banked data memory address unit

This unit turns the short operand offsets of a small 8-bit core into 12-bit data memory addresses and performs the resulting byte accesses. The 4096-byte data space is split into 16 banks of 256 bytes. A 4-bit bank register supplies the upper address bits in banked mode. A fixed 256-byte fast window, chosen with an access-mode bit, reaches the bottom of bank 0 and the top of the address space without touching the bank register. A two-cycle full-address copy takes explicit 12-bit source and target addresses and does not consult the bank register.

The RAM is behavioural and built per bank. A parameter mask picks the banks that exist. Stores aimed at a missing bank are dropped, and loads from one return zero. The core issues one request per cycle on a flat request port and picks up read data on the following cycle.

Top module: `bank_addr_unit`

## Requirements
- R1: In banked mode (`req_acc`=0), an access uses address {bank register[3:0], `req_ofs`}.
- R2: When `bsr_load` is accepted, the bank register takes `bsr_lit[3:0]` at the clock edge. `bsr_q` shows it in bits 3:0, and bits 7:4 of `bsr_q` are always 0 whatever `bsr_lit[7:4]` holds. The new value takes effect for accesses from the next cycle on. Without a load the register holds its value.
- R3: In access mode (`req_acc`=1), offsets 0x00–0x7F address 0x000–0x07F and offsets 0x80–0xFF address 0xF80–0xFFF, regardless of the bank register.
- R4: A full-address copy (`req_full`=1) reads `req_src`, and in the next cycle raises `busy` for one cycle with `rdata` equal to the source byte. At the end of that cycle the byte is written to `req_dst`. The bank register plays no part.
- R5: With `IMPL_MASK` bit b at 0, writes to bank b are discarded and reads from bank b return 0x00. This holds for the copy as well.
- R6: `rdata` carries the addressed byte in the cycle after a read or copy request. In every other cycle it is 0x00.
- R7: Reset clears the bank register, `busy` and `rdata` to 0 and leaves the RAM contents as they were.
- R8: While `busy` is high, `req_rd`, `req_wr`, `req_full` and `bsr_load` are all ignored.
- R9: A write followed by a read of the same address, or a read and write of it in the same cycle, returns the newly written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request |
| req_acc | input | 1 | 1 = access window, 0 = banked |
| req_ofs | input | 8 | Offset within bank or window |
| req_wdata | input | 8 | Write data |
| req_full | input | 1 | Start full-address copy |
| req_src | input | 12 | Copy source address |
| req_dst | input | 12 | Copy target address |
| bsr_load | input | 1 | Load bank register |
| bsr_lit | input | 8 | Literal for bank register |
| rdata | output | 8 | Read data, one cycle after request |
| bsr_q | output | 8 | Bank register value, upper nibble zero |
| busy | output | 1 | Copy in its second cycle |

## Verification
The properties assume every request input is a known level at each rising edge and that reset is released in step with the clock. They do not model what the core does with `busy`; the design itself drops requests during that cycle. The stimulus changes inputs only on falling edges and holds every input at a defined value, including zeros between directed operations. It also issues requests during the busy cycle on purpose, so that the property on ignored requests is exercised.

// File: rtl/bau_pkg.sv
package bau_pkg;
  parameter int DATA_W   = 8;
  parameter int OFS_W    = 8;
  parameter int BANK_W   = 4;
  localparam int ADDR_W    = BANK_W + OFS_W;
  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int BANK_SZ   = 1 << OFS_W;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BANK_W-1:0] bank_t;
  typedef logic [OFS_W-1:0]  ofs_t;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/bau_bank_reg.sv
module bau_bank_reg
  import bau_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_en,
  input  byte_t lit,
  output bank_t bank,
  output byte_t bank_rd
);
  bank_t bank_q;
  bank_t bank_d;

  always_comb begin
    bank_d = bank_q;
    if (ld_en) bank_d = BANK_W'(lit & byte_t'((1 << BANK_W) - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  assign bank    = bank_q;
  assign bank_rd = {{(DATA_W-BANK_W){1'b0}}, bank_q};
endmodule

// File: rtl/bau_addr_sel.sv
module bau_addr_sel
  import bau_pkg::*;
(
  input  bank_t bank,
  input  ofs_t  ofs,
  input  logic  acc,
  output addr_t eff
);
  bank_t win_bank;

  always_comb begin
    // lower half of the window sits in bank 0, upper half in the top bank
    win_bank = ofs[OFS_W-1] ? bank_t'(NUM_BANKS - 1) : '0;
    eff      = acc ? {win_bank, ofs} : {bank, ofs};
  end
endmodule

// File: rtl/bau_ram.sv
module bau_ram
  import bau_pkg::*;
#(
  parameter logic [NUM_BANKS-1:0] IMPL_MASK = '1
)(
  input  logic  clk,
  input  logic  wr_en,
  input  addr_t wr_addr,
  input  byte_t wr_data,
  input  addr_t rd_addr,
  output byte_t rd_byte
);
  byte_t bank_out [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    if (IMPL_MASK[b]) begin : g_impl
      byte_t store [BANK_SZ];
      logic  sel;
      assign sel = wr_en && (wr_addr[ADDR_W-1:OFS_W] == bank_t'(b));
      always_ff @(posedge clk) begin
        if (sel) store[wr_addr[OFS_W-1:0]] <= wr_data;
      end
      assign bank_out[b] = store[rd_addr[OFS_W-1:0]];
    end else begin : g_absent
      assign bank_out[b] = '0;
    end
  end

  assign rd_byte = bank_out[rd_addr[ADDR_W-1:OFS_W]];
endmodule

// File: rtl/bank_addr_unit.sv
module bank_addr_unit
  import bau_pkg::*;
#(
  parameter logic [NUM_BANKS-1:0] IMPL_MASK = '1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic              req_acc,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_full,
  input  logic [ADDR_W-1:0] req_src,
  input  logic [ADDR_W-1:0] req_dst,
  input  logic              bsr_load,
  input  logic [DATA_W-1:0] bsr_lit,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] bsr_q,
  output logic              busy
);
  bank_t bank;
  addr_t eff;
  addr_t addr_q, addr_d, dst_q;
  logic  addr_en, dst_en;
  logic  rvalid_q, rvalid_d, mv_q, mv_d;
  logic  accept;
  logic  ram_we;
  addr_t ram_waddr;
  byte_t ram_wdata, ram_rd;

  assign accept = !mv_q;

  bau_bank_reg u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (accept && bsr_load),
    .lit     (bsr_lit),
    .bank    (bank),
    .bank_rd (bsr_q)
  );

  bau_addr_sel u_sel (
    .bank (bank),
    .ofs  (req_ofs),
    .acc  (req_acc),
    .eff  (eff)
  );

  always_comb begin
    addr_en   = accept && (req_full || req_rd);
    addr_d    = req_full ? req_src : eff;
    dst_en    = accept && req_full;
    rvalid_d  = addr_en;
    mv_d      = dst_en;
    ram_we    = mv_q || (accept && !req_full && req_wr);
    ram_waddr = mv_q ? dst_q : eff;
    ram_wdata = mv_q ? ram_rd : req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      mv_q     <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      mv_q     <= mv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= addr_d;
    if (dst_en)  dst_q  <= req_dst;
  end

  bau_ram #(.IMPL_MASK(IMPL_MASK)) u_ram (
    .clk     (clk),
    .wr_en   (ram_we),
    .wr_addr (ram_waddr),
    .wr_data (ram_wdata),
    .rd_addr (addr_q),
    .rd_byte (ram_rd)
  );

  assign rdata = rvalid_q ? ram_rd : '0;
  assign busy  = mv_q;
endmodule

// File: rtl/bau_chk.sv
module bau_chk
  import bau_pkg::*;
#(
  parameter logic [NUM_BANKS-1:0] IMPL_MASK = '1
)(
  input logic              clk,
  input logic              rst_n,
  input logic              req_rd,
  input logic              req_full,
  input logic [BANK_W-1:0] src_bank,
  input logic              bsr_load,
  input logic [BANK_W-1:0] lit_lo,
  input logic              busy,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] bsr_q
);
  a_r2_bsr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bsr_load && !busy) |=> bsr_q == {{(DATA_W-BANK_W){1'b0}}, $past(lit_lo)});

  a_r8_bsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bsr_load || busy) |=> $stable(bsr_q));

  a_r4_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (req_full && !busy) |=> busy);

  a_r4_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_full || busy) |=> !busy);

  a_r6_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || (!req_rd && !req_full)) |=> rdata == '0);

  a_r5_absent_src: assert property (@(posedge clk) disable iff (!rst_n)
    (req_full && !busy && !IMPL_MASK[src_bank]) |=> rdata == '0);
endmodule

bind bank_addr_unit bau_chk #(.IMPL_MASK(IMPL_MASK)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_rd   (req_rd),
  .req_full (req_full),
  .src_bank (req_src[11:8]),
  .bsr_load (bsr_load),
  .lit_lo   (bsr_lit[3:0]),
  .busy     (busy),
  .rdata    (rdata),
  .bsr_q    (bsr_q)
);

// File: tb/bank_addr_unit_tb_top.sv
`timescale 1ns/1ps
module bank_addr_unit_tb_top;
  localparam logic [15:0] MASK = 16'hBFFB; // banks 2 and 14 absent

  logic clk = 1'b0;
  logic rst_n, req_rd, req_wr, req_acc, req_full, bsr_load, busy;
  logic [7:0] req_ofs, req_wdata, bsr_lit, rdata, bsr_q;
  logic [11:0] req_src, req_dst;

  always #4 clk = ~clk;

  bank_addr_unit #(.IMPL_MASK(MASK)) dut_i (.*);

  int checks = 0, fails = 0;
  int m_mem [4096];
  int m_bsr, m_busy, m_src, m_dst, exp_rd;

  function automatic bit impl(int a);
    return MASK[(a >> 8) & 15];
  endfunction

  function automatic int rd_model(int a);
    return impl(a) ? m_mem[a] : 0;
  endfunction

  task automatic model_step();
    int eff;
    if (!rst_n) begin
      m_bsr = 0; m_busy = 0; exp_rd = 0;
      return;
    end
    if (m_busy != 0) begin
      if (impl(m_dst)) m_mem[m_dst] = rd_model(m_src);
      m_busy = 0; exp_rd = 0;
      return;
    end
    eff = req_acc ? (req_ofs[7] ? 'hF00 + req_ofs : req_ofs) : m_bsr * 256 + req_ofs;
    if (req_full) begin
      m_src = req_src; m_dst = req_dst; m_busy = 1;
      exp_rd = rd_model(m_src);
    end else begin
      if (req_wr && impl(eff)) m_mem[eff] = req_wdata;
      exp_rd = req_rd ? rd_model(eff) : 0;
    end
    if (bsr_load) m_bsr = bsr_lit & 15;
  endtask

  task automatic tick(input string tag);
    @(posedge clk); #1;
    model_step();
    @(negedge clk);
    checks++;
    if (rdata !== 8'(exp_rd) || busy !== 1'(m_busy) || bsr_q !== 8'(m_bsr)) begin
      fails++;
      $display("FAIL %s rdata=%h/%h busy=%b/%0d bsr=%h/%h (actual/expected)",
               tag, rdata, 8'(exp_rd), busy, m_busy, bsr_q, 8'(m_bsr));
    end
  endtask

  task automatic idle();
    req_rd = 0; req_wr = 0; req_acc = 0; req_full = 0; bsr_load = 0;
    req_ofs = 0; req_wdata = 0; bsr_lit = 0; req_src = 0; req_dst = 0;
  endtask

  task automatic load(input logic [7:0] lit, input string tag);
    idle(); bsr_load = 1; bsr_lit = lit; tick(tag); idle();
  endtask

  task automatic wr(input logic [7:0] o, input logic a, input logic [7:0] d, input string tag);
    idle(); req_wr = 1; req_ofs = o; req_acc = a; req_wdata = d; tick(tag); idle();
  endtask

  task automatic rd(input logic [7:0] o, input logic a, input string tag);
    idle(); req_rd = 1; req_ofs = o; req_acc = a; tick(tag); idle(); tick(tag);
  endtask

  task automatic mv(input logic [11:0] s, input logic [11:0] d, input string tag);
    idle(); req_full = 1; req_src = s; req_dst = d; tick(tag); idle(); tick(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(); rst_n = 0;
    m_bsr = 0; m_busy = 0; exp_rd = 0; m_src = 0; m_dst = 0;
    for (int i = 0; i < 4096; i++) m_mem[i] = 0;
    repeat (3) tick("R7 reset");
    @(negedge clk); rst_n = 1;

    // fill every location through banked writes; upper literal nibble is junk
    for (int b = 0; b < 16; b++) begin
      load(8'((b ^ 5) << 4 | b), "R2 load");
      for (int o = 0; o < 256; o++) wr(8'(o), 0, 8'((b * 256 + o) * 7 + 3), "R1 fill");
    end
    // absent banks read zero
    load(8'h02, "R2"); rd(8'h10, 0, "R5 absent read");
    load(8'hF3, "R2 upper nibble"); rd(8'h44, 0, "R1 banked read");
    load(8'h0E, "R2"); wr(8'h20, 0, 8'h5A, "R5 absent write"); rd(8'h20, 0, "R5");
    // access window around the split point, bank register pointing elsewhere
    load(8'h05, "R2");
    rd(8'h7F, 1, "R3 low edge"); rd(8'h80, 1, "R3 high edge");
    rd(8'h00, 1, "R3"); rd(8'hFF, 1, "R3");
    wr(8'h7F, 1, 8'hA1, "R3 write"); wr(8'h80, 1, 8'hB2, "R3 write");
    load(8'h00, "R2"); rd(8'h7F, 0, "R3 check bank0");
    load(8'h0F, "R2"); rd(8'h80, 0, "R3 check bank15");
    // load takes effect next cycle: load and write in one cycle uses old bank
    idle(); bsr_load = 1; bsr_lit = 8'h03; req_wr = 1; req_ofs = 8'h11; req_wdata = 8'hC4;
    tick("R2 same-cycle"); idle();
    rd(8'h11, 0, "R2"); load(8'h0F, "R2"); rd(8'h11, 0, "R2 old bank");
    // read and write in one cycle, then back-to-back write/read
    idle(); req_rd = 1; req_wr = 1; req_ofs = 8'h33; req_wdata = 8'h9E;
    tick("R9"); idle(); tick("R9 same cycle");
    wr(8'h34, 0, 8'h6D, "R9"); rd(8'h34, 0, "R9 next cycle");
    // full-address copies
    load(8'h07, "R2");
    mv(12'h345, 12'h9AB, "R4 copy");
    load(8'h09, "R2"); rd(8'hAB, 0, "R4 copy result");
    mv(12'h210, 12'h511, "R5 absent src"); rd(8'h11, 0, "R5");
    mv(12'h512, 12'hE12, "R5 absent dst");
    load(8'h0E, "R2"); rd(8'h12, 0, "R5");
    mv(12'hF80, 12'h07F, "R4 copy window");
    // requests during the busy cycle are dropped
    load(8'h04, "R2");
    idle(); req_full = 1; req_src = 12'h100; req_dst = 12'h101; tick("R8");
    req_full = 1; req_src = 12'h300; req_dst = 12'h301;
    req_wr = 1; req_rd = 1; req_ofs = 8'h55; req_wdata = 8'h00;
    bsr_load = 1; bsr_lit = 8'h0C; tick("R8 busy");
    idle(); tick("R8 after");
    rd(8'h55, 0, "R8 write dropped");
    load(8'h01, "R2"); rd(8'h01, 0, "R4");
    load(8'h03, "R2"); rd(8'h01, 0, "R8 copy dropped");
    // idle cycles
    repeat (4) tick("R6 idle");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      idle();
      req_rd = 1'($urandom); req_wr = 1'($urandom); req_acc = 1'($urandom);
      req_ofs = 8'($urandom); req_wdata = 8'($urandom);
      req_full = ($urandom % 8) == 0;
      req_src = 12'($urandom); req_dst = 12'($urandom);
      bsr_load = ($urandom % 4) == 0; bsr_lit = 8'($urandom);
      tick("R1 random");
    end
    // reset keeps RAM
    idle(); load(8'h09, "R2");
    @(negedge clk); rst_n = 0; tick("R7 mid reset");
    @(negedge clk); rst_n = 1;
    rd(8'h45, 0, "R7 ram kept");
    mv(12'h9AB, 12'h000, "R7"); rd(8'h00, 1, "R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule